// File: doc/BRIEF.md
# A/D Converter Register Front End

This block is the digital side of a 10-bit, 12-channel successive-approximation converter. Software reaches it through a small register port. It writes a mode byte, a channel number and a port-configuration nibble. It clears the sticky end-of-conversion flag, and it reads back either the left-justified 16-bit result or the upper eight result bits alone. The analog core is replaced by a stub. Once the mode byte enables it, the stub converts the selected channel over and over. Each result becomes ready a fixed number of clock cycles after its conversion starts.

The main job of the block is to decide what happens when a finished conversion lands in the same clock cycle as a processor access. A coincident read of the result gets the old value, and the new value is stored one cycle later. A coincident configuration write wins: the finished sample is thrown away and no interrupt is raised for it. The interrupt output is a single-cycle pulse in the cycle the result register is actually loaded. A sticky copy of it stays set until software clears it.

Top module: `adc_front`

## Requirements
- R1: After reset the result is 0, the mode, channel and port-configuration registers are 0, `irq` is low and `irq_flag` is low.
- R2: The converter runs only when mode bits 7 and 0 are both 1. With either bit clear, no result is produced and `irq` stays low. Write select 0 loads the mode byte, and read select 2 returns it in bits 7:0.
- R3: The first result is loaded 22 clock edges after the write that enables the converter, and `irq` is high for exactly the cycle before that edge. While the converter stays enabled, further results follow every 22 cycles.
- R4: Read select 0 returns the result left-justified: the result in bits 15:6 and zeros in bits 5:0. Read select 1 returns the upper 8 result bits in bits 7:0 and zeros above them.
- R5: The stub's sample for channel c is (83*c + 37*n + 5) mod 1024. Here n is the number of conversions finished since reset, counting the ones that were discarded.
- R6: If a conversion finishes in a cycle with a result read (select 0 or 1), the read returns the old value and `irq` stays low. The new value is loaded at the following edge, with `irq` high in that following cycle.
- R7: If a conversion finishes in a cycle with a write to the mode, channel or port-configuration register (selects 0, 1, 2), the write takes effect, the result is kept unchanged and no `irq` pulse is produced for that sample.
- R8: `irq_flag` becomes 1 at the edge where a result is loaded. A write with select 3 clears it. If a load and a clear fall on the same edge, the flag is set.
- R9: A channel write while the converter runs aborts the conversion in progress. The next result, taken on the new channel, is loaded 22 edges after that write.
- R10: A channel write with a value above 11 leaves the channel register unchanged. Read select 3 returns the port configuration in bits 15:8 and the channel in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 channel, 2 port config, 3 flag clear |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read source: 0 full result, 1 high byte, 2 mode, 3 config |
| rd_data | output | 16 | Read data (combinational) |
| irq | output | 1 | One-cycle conversion-end pulse |
| irq_flag | output | 1 | Sticky conversion-end flag |

## Verification
The assertions assume that a deferred result is never followed, in the very next cycle, by another finished conversion. Conversions are 22 cycles long, so two completions can never be adjacent. They also assume that `wr_sel` and `rd_sel` are only meaningful when their strobes are high. The bench drives each strobe for single cycles at the falling edge. It uses a cycle-accurate model of its own to place reads and writes exactly on a completion cycle, so each conflict is produced on purpose rather than by chance.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
  localparam int RES_W    = 10;
  localparam int N_CH     = 12;
  localparam int CH_W     = 4;
  localparam int PCFG_W   = 4;
  localparam int SEQ_W    = 10;
  localparam int CONV_CYC = 22;

  typedef enum logic [1:0] {WR_MODE = 2'd0, WR_CHAN = 2'd1, WR_PCFG = 2'd2, WR_FLAG = 2'd3} wr_sel_e;
  typedef enum logic [1:0] {RD_FULL = 2'd0, RD_HIGH = 2'd1, RD_MODE = 2'd2, RD_CFG = 2'd3} rd_sel_e;

  // stub sample: (83*ch + 37*seq + 5) mod 2^RES_W
  function automatic logic [RES_W-1:0] stub_sample(input logic [CH_W-1:0] ch,
                                                   input logic [SEQ_W-1:0] sq);
    logic [31:0] acc;
    acc = 32'(ch) * 32'd83 + 32'(sq) * 32'd37 + 32'd5;
    return acc[RES_W-1:0];
  endfunction

  function automatic logic [15:0] left_just(input logic [RES_W-1:0] r);
    return {r, {(16-RES_W){1'b0}}};
  endfunction

  function automatic logic [15:0] high_byte(input logic [RES_W-1:0] r);
    return {8'h00, r[RES_W-1 -: 8]};
  endfunction
endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
  import adc_fe_pkg::*;
#(
  parameter int CH_W_P   = CH_W,
  parameter int N_CH_P   = N_CH,
  parameter int PCFG_W_P = PCFG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [7:0]          wr_data,
  output logic [7:0]          mode_q,
  output logic [CH_W_P-1:0]   chan_q,
  output logic [PCFG_W_P-1:0] pcfg_q,
  output logic                cfg_wr,
  output logic                chan_restart,
  output logic                flag_clr
);
  logic chan_ok;

  assign cfg_wr       = wr_en && (wr_sel != WR_FLAG);
  assign chan_ok      = 32'(wr_data) < N_CH_P;
  assign chan_restart = wr_en && (wr_sel == WR_CHAN) && chan_ok;
  assign flag_clr     = wr_en && (wr_sel == WR_FLAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      chan_q <= '0;
      pcfg_q <= '0;
    end else begin
      if (wr_en && wr_sel == WR_MODE) mode_q <= wr_data;
      if (chan_restart)               chan_q <= wr_data[CH_W_P-1:0];
      if (wr_en && wr_sel == WR_PCFG) pcfg_q <= wr_data[PCFG_W_P-1:0];
    end
  end
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub
  import adc_fe_pkg::*;
#(
  parameter int CONV_CYC_P = CONV_CYC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CH_W-1:0]  chan,
  output logic             done,
  output logic [RES_W-1:0] data
);
  localparam int CNT_W = $clog2(CONV_CYC_P);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYC_P - 1);

  logic [CNT_W-1:0] cnt;
  logic [SEQ_W-1:0] seq;

  assign done = run && (cnt == LAST);
  assign data = stub_sample(chan, seq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      seq <= '0;
    end else begin
      if (!run || restart || done) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
      if (done) seq <= seq + 1'b1;
    end
  end
endmodule

// File: rtl/adc_result_arb.sv
module adc_result_arb
  import adc_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [RES_W-1:0] data,
  input  logic             cfg_wr,
  input  logic             rd_res,
  input  logic             flag_clr,
  output logic [RES_W-1:0] res_q,
  output logic             commit,
  output logic             deferred,
  output logic             dropped,
  output logic             irq_flag
);
  logic             pend_v;
  logic [RES_W-1:0] pend_d;
  logic [RES_W-1:0] wdata;

  assign dropped  = done && cfg_wr;
  assign deferred = done && !cfg_wr && rd_res;
  assign commit   = pend_v || (done && !cfg_wr && !rd_res);
  assign wdata    = pend_v ? pend_d : data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_d   <= '0;
      res_q    <= '0;
      irq_flag <= 1'b0;
    end else begin
      pend_v <= deferred;
      if (deferred) pend_d <= data;
      if (commit)   res_q  <= wdata;
      if (commit)        irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_front.sv
module adc_front
  import adc_fe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_sel,
  output logic [15:0] rd_data,
  output logic        irq,
  output logic        irq_flag
);
  logic [7:0]        mode_q;
  logic [CH_W-1:0]   chan_q;
  logic [PCFG_W-1:0] pcfg_q;
  logic              cfg_wr, chan_restart, flag_clr;
  logic              run, done, rd_res, commit, deferred, dropped;
  logic [RES_W-1:0]  conv_data, res_q;

  assign run    = mode_q[7] & mode_q[0];
  assign rd_res = rd_en && (rd_sel == RD_FULL || rd_sel == RD_HIGH);
  assign irq    = commit;

  adc_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_q(mode_q), .chan_q(chan_q), .pcfg_q(pcfg_q),
    .cfg_wr(cfg_wr), .chan_restart(chan_restart), .flag_clr(flag_clr)
  );

  adc_conv_stub u_stub (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(chan_restart),
    .chan(chan_q), .done(done), .data(conv_data)
  );

  adc_result_arb u_arb (
    .clk(clk), .rst_n(rst_n), .done(done), .data(conv_data), .cfg_wr(cfg_wr),
    .rd_res(rd_res), .flag_clr(flag_clr), .res_q(res_q), .commit(commit),
    .deferred(deferred), .dropped(dropped), .irq_flag(irq_flag)
  );

  always_comb begin
    unique case (rd_sel)
      RD_FULL: rd_data = left_just(res_q);
      RD_HIGH: rd_data = high_byte(res_q);
      RD_MODE: rd_data = {8'h00, mode_q};
      default: rd_data = {8'(pcfg_q), 8'(chan_q)};
    endcase
  end
endmodule

// File: rtl/adc_front_chk.sv
module adc_front_chk
  import adc_fe_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             done,
  input logic             cfg_wr,
  input logic             rd_res,
  input logic             commit,
  input logic [RES_W-1:0] res_q,
  input logic [RES_W-1:0] conv_data,
  input logic             irq_flag,
  input logic             flag_clr,
  input logic [CH_W-1:0]  chan_q,
  input logic             rd_en,
  input logic [1:0]       rd_sel,
  input logic [15:0]      rd_data
);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !done);
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_wr && !rd_res) |=> res_q == $past(conv_data));
  p_high_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == 2'd1) |-> rd_data[15:8] == 8'h00);
  p_defer_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_wr && rd_res) |-> !commit);
  p_defer_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_wr && rd_res) |=> commit && res_q == $past(res_q));
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_wr) |-> !commit);
  p_drop_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_wr) |=> $stable(res_q));
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n) commit |=> irq_flag);
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);
  p_chan_range_r10: assert property (@(posedge clk) disable iff (!rst_n) 32'(chan_q) < N_CH);
endmodule

bind adc_front adc_front_chk i_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .done(done), .cfg_wr(cfg_wr), .rd_res(rd_res),
  .commit(commit), .res_q(res_q), .conv_data(conv_data), .irq_flag(irq_flag),
  .flag_clr(flag_clr), .chan_q(chan_q), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/test_adc_front.sv
`timescale 1ns/1ps
module test_adc_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] rd_data;
  logic        irq, irq_flag;

  int n_tests = 0, n_fail = 0;
  int irq_seen = 0, irq_mis = 0, flag_mis = 0;

  // reference model state
  logic [7:0] mode_m = 0;
  int chan_m = 0, pcfg_m = 0, cnt_m = 0, seq_m = 0, res_m = 0, pend_dm = 0;
  bit pend_m = 0, flag_m = 0;

  localparam logic [3:0] CH_TAB [6] = '{4'd3, 4'd7, 4'd11, 4'd0, 4'd5, 4'd9};

  adc_front i_adc_front (.*);

  always #10 clk = ~clk;

  function automatic int smp(int ch, int sq);
    return (ch * 83 + sq * 37 + 5) % 1024;
  endfunction

  always @(posedge clk) begin
    bit act, dn, cfgw, rdr, clr, chok, cm;
    int wv;
    if (!rst_n) begin
      mode_m = 0; chan_m = 0; pcfg_m = 0; cnt_m = 0; seq_m = 0;
      res_m = 0; pend_m = 0; pend_dm = 0; flag_m = 0;
    end else begin
      act  = mode_m[7] && mode_m[0];
      dn   = act && cnt_m == 21;
      cfgw = wr_en && wr_sel != 2'd3;
      rdr  = rd_en && rd_sel < 2'd2;
      clr  = wr_en && wr_sel == 2'd3;
      chok = wr_en && wr_sel == 2'd1 && wr_data < 8'd12;
      cm   = pend_m || (dn && !cfgw && !rdr);
      if (irq !== cm) irq_mis++;
      if (irq_flag !== flag_m) flag_mis++;
      if (irq) irq_seen++;
      wv = pend_m ? pend_dm : smp(chan_m, seq_m);
      if (cm) begin res_m = wv; flag_m = 1; end
      else if (clr) flag_m = 0;
      pend_m = dn && !cfgw && rdr;
      if (pend_m) pend_dm = smp(chan_m, seq_m);
      if (!act || chok || dn) cnt_m = 0; else cnt_m++;
      if (dn) seq_m++;
      if (wr_en && wr_sel == 2'd0) mode_m = wr_data;
      if (chok) chan_m = int'(wr_data);
      if (wr_en && wr_sel == 2'd2) pcfg_m = int'(wr_data[3:0]);
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0; #1;
  endtask

  task automatic rd(logic [1:0] s, output int v);
    @(negedge clk); rd_en = 1; rd_sel = s; #1; v = int'(rd_data);
    @(negedge clk); rd_en = 0; #1;
  endtask

  // cycles from the current cycle until irq is seen
  task automatic wait_irq(output int k);
    k = 0;
    while (!irq && k < 200) begin @(negedge clk); #1; k++; end
  endtask

  // stop at the negedge of a cycle in which a conversion finishes
  task automatic wait_done();
    @(negedge clk); #1;
    while (!(mode_m[7] && mode_m[0] && cnt_m == 21)) begin @(negedge clk); #1; end
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_up();
  end

  initial begin
    int v, k, base, old, expv, sq;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(irq == 0 && irq_flag == 0, "R1 irq/flag", int'({irq, irq_flag}), 0);
    rd(2'd0, v); chk(v == 0, "R1 result", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 mode", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 config", v, 0);

    // R2 partial enables do not run
    base = irq_seen;
    wr(2'd0, 8'h80); repeat (30) @(negedge clk);
    rd(2'd2, v); chk(v == 8'h80, "R2 mode readback", v, 8'h80);
    wr(2'd0, 8'h01); repeat (30) @(negedge clk);
    chk(irq_seen == base, "R2 no irq when half enabled", irq_seen - base, 0);
    rd(2'd0, v); chk(v == 0, "R2 result untouched", v, 0);

    // R3 start latency and period, R4/R5 first value
    wr(2'd0, 8'h81);
    wait_irq(k); chk(k == 21, "R3 first result latency", k, 21);
    @(negedge clk); #1;
    chk(irq_flag == 1, "R8 flag set on load", int'(irq_flag), 1);
    wait_irq(k); chk(k == 21, "R3 period", k + 1, 22);
    @(negedge clk); #1;
    rd(2'd0, v); chk(v == (smp(0, 1) << 6), "R4 R5 full result", v, smp(0, 1) << 6);
    rd(2'd1, v); chk(v == (smp(0, 1) >> 2), "R4 high byte", v, smp(0, 1) >> 2);

    // R9 table of channel switches while running
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, {4'd0, CH_TAB[i]});
      sq = seq_m;
      wait_irq(k); chk(k == 21, "R9 restart latency", k, 21);
      @(negedge clk); #1;
      expv = smp(int'(CH_TAB[i]), sq);
      rd(2'd0, v); chk(v == (expv << 6), "R9 R5 value on new channel", v, expv << 6);
      rd(2'd1, v); chk(v == (expv >> 2), "R4 high byte table", v, expv >> 2);
    end

    // R10 out-of-range channel ignored
    wr(2'd1, 8'd12);
    rd(2'd3, v); chk(v == 9, "R10 channel kept", v, 9);
    wr(2'd1, 8'd15);
    rd(2'd3, v); chk((v & 8'hFF) == 9, "R10 channel kept 15", v, 9);

    // R6 read conflict
    wait_done();
    old = res_m; expv = smp(chan_m, seq_m);
    rd_en = 1; rd_sel = 2'd0; #1;
    chk(int'(rd_data) == (old << 6), "R6 read returns old", int'(rd_data), old << 6);
    chk(irq == 0, "R6 no irq in read cycle", int'(irq), 0);
    @(negedge clk); rd_en = 0; #1;
    chk(irq == 1, "R6 irq next cycle", int'(irq), 1);
    @(negedge clk); #1;
    rd(2'd0, v); chk(v == (expv << 6), "R6 deferred value", v, expv << 6);

    // R7 config write conflict
    wait_done();
    old = res_m; sq = seq_m; base = irq_seen;
    wr_en = 1; wr_sel = 2'd2; wr_data = 8'h05; #1;
    chk(irq == 0, "R7 no irq on conflict", int'(irq), 0);
    @(negedge clk); wr_en = 0; #1;
    rd(2'd0, v); chk(v == (old << 6), "R7 result kept", v, old << 6);
    rd(2'd3, v); chk((v >> 8) == 5, "R7 config write took effect", v >> 8, 5);
    wait_irq(k);
    chk(irq_seen == base, "R7 dropped irq", irq_seen - base, 0);
    @(negedge clk); #1;
    expv = smp(chan_m, sq + 1);
    rd(2'd0, v); chk(v == (expv << 6), "R5 R7 sequence counts dropped sample", v, expv << 6);

    // R8 clear and set-over-clear
    wr(2'd3, 8'h00);
    chk(irq_flag == 0, "R8 flag cleared", int'(irq_flag), 0);
    wait_done();
    wr_en = 1; wr_sel = 2'd3; #1;
    chk(irq == 1, "R8 load with clear still irqs", int'(irq), 1);
    @(negedge clk); wr_en = 0; #1;
    chk(irq_flag == 1, "R8 set wins over clear", int'(irq_flag), 1);

    // R2 stop
    wr(2'd0, 8'h00); base = irq_seen;
    repeat (50) @(negedge clk);
    chk(irq_seen == base, "R2 stopped no irq", irq_seen - base, 0);
    chk(irq_flag == 1, "R8 flag held while stopped", int'(irq_flag), 1);

    chk(irq_mis == 0, "R3 irq cycle-exact vs model", irq_mis, 0);
    chk(flag_mis == 0, "R8 flag cycle-exact vs model", flag_mis, 0);
    finish_up();
  end
endmodule